// File: doc/BRIEF.md
# Leakage-Speed Cell State Recovery Engine

This engine is used after a flash page has already failed ECC decoding and its contents have been saved. Each cell of the page arrives as a pair of quantized threshold-voltage readings. The first reading is taken when the failure is found. The second is taken after a further retention interval. The engine uses the three read references and a window half-width to mark as risky every cell whose first reading sits close to the boundary between the two highest programmed levels. For such a cell the sharp threshold comparison cannot be trusted. The engine instead resolves it from how fast the cell is losing charge. A cell that drops a lot between readings was most likely programmed to the higher level; a cell that drops little most likely belonged to the lower one.

Cells flow in and out on valid/ready streams at one cell per cycle. A start pulse latches the page length, clears the statistics and opens the page. After the last corrected cell has left the output, the engine raises a done flag and holds the number of risky cells and the number of cells whose state it changed. Sampling the flash and the final ECC decode happen outside the block.

Top module: `leak_recover_top`

## Requirements
- R1: While reset is asserted, and until the first start pulse, `in_ready`, `out_valid` and `done` are low and both counters read zero.
- R2: A cell that is not risky is decoded from its first reading v: v < `ref_lo` gives 2'b11, v < `ref_mid` gives 2'b10, v < `ref_opt` gives 2'b00, and any other value gives 2'b01.
- R3: A cell is risky when its first reading lies in the inclusive range from `ref_opt - win` to `ref_opt + win`. The lower bound saturates at zero and the upper bound is computed one bit wider, so neither bound wraps around.
- R4: The leakage of a cell is the first reading minus the second, taken as zero when the second reading is higher. The cell counts as fast when its leakage is greater than or equal to `fast_thr`.
- R5: A risky slow cell is output as 2'b00 and a risky fast cell as 2'b01, whatever its threshold decode.
- R6: A cell is taken only on a cycle where `in_valid` and `in_ready` are both high. `in_ready` is high only inside an open page, outside a start cycle, and when the output slot is empty or being drained. The engine then passes one cell per cycle, and corrected cells leave in the order they arrived.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_lvl` does not change.
- R8: Once `page_cells` cells have been taken, `in_ready` stays low until the next start pulse, even if `in_valid` is held high.
- R9: `risky_cnt` counts the risky cells taken in the page. `changed_cnt` counts those whose output differs from their threshold decode.
- R10: A start pulse clears both counters and `done` and aborts any pending output. `done` rises on the cycle after the last cell's output transfer and stays high until the next start. When `page_cells` is zero, `done` rises on the cycle after start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a new page, clears counters and done |
| page_cells | input | CW | Number of cells in the page, latched at start |
| ref_lo | input | VW | Erased/first-level read reference |
| ref_mid | input | VW | First/second-level read reference |
| ref_opt | input | VW | Optimal reference between the two top levels |
| win | input | VW | Half-width of the risk window |
| fast_thr | input | VW | Leakage at or above which a cell is fast |
| in_valid | input | 1 | Input sample pair valid |
| in_ready | output | 1 | Engine can take a sample pair |
| in_v1 | input | VW | First threshold-voltage reading |
| in_v2 | input | VW | Second, later threshold-voltage reading |
| out_valid | output | 1 | Corrected cell valid |
| out_ready | input | 1 | Consumer takes the corrected cell |
| out_lvl | output | 2 | Corrected two-bit cell state |
| risky_cnt | output | CW | Risky cells in the current page |
| changed_cnt | output | CW | Cells whose state was changed |
| done | output | 1 | Page finished; counters are final |

## Verification
The bench places cells exactly on both window edges and one step outside them, and places leakage exactly on the fast threshold and one below it. An off-by-one comparison would move a cell to the wrong level and leave the changed count off by one. A second reading above the first checks that leakage saturates: a design that wraps would call the cell fast. Windows near both ends of the voltage range catch bounds that wrap and then mark nothing, or everything, as risky. Random stalls on both streams, together with a source that keeps offering cells after the page is full, expose dropped or repeated cells and overrun of the page length. A zero-length page and a restart after a busy page show whether done and the counters are cleared and raised on the right cycle.

// File: rtl/leak_recover_pkg.sv
// Shared codes and types for the leakage-speed recovery engine.
// Assumes a two-bit cell code with the erased level as 2'b11.
package leak_recover_pkg;

    // Two-bit cell codes, lowest level to highest level.
    localparam logic [1:0] LVL_ER = 2'b11;
    localparam logic [1:0] LVL_L1 = 2'b10;
    localparam logic [1:0] LVL_L2 = 2'b00;
    localparam logic [1:0] LVL_L3 = 2'b01;

    // Page phase of the controller.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RUN  = 2'd1,
        PH_DONE = 2'd2
    } phase_t;

    // Word held in the output slot.
    typedef struct packed {
        logic [1:0] lvl;
        logic       last;
    } out_word_t;

endpackage

// File: rtl/lr_classify.sv
// Combinational per-cell classifier.
// Decodes the first reading against three references. Flags the cell as
// risky when that reading falls in the window around the optimal
// reference, then resolves risky cells by leakage speed.
// Assumes ref_lo <= ref_mid <= ref_opt; no state is held.
module lr_classify
    import leak_recover_pkg::*;
#(
    parameter int VW = 8
) (
    input  logic [VW-1:0] v1,
    input  logic [VW-1:0] v2,
    input  logic [VW-1:0] ref_lo,
    input  logic [VW-1:0] ref_mid,
    input  logic [VW-1:0] ref_opt,
    input  logic [VW-1:0] win,
    input  logic [VW-1:0] fast_thr,
    output logic [1:0]    lvl,
    output logic          risky,
    output logic          changed
);

    logic [VW:0]   lo_x;
    logic [VW:0]   hi_x;
    logic [VW-1:0] drop;
    logic          fast;
    logic [1:0]    plain_lvl;

    // Window bounds, one bit wider so neither bound wraps.
    always_comb begin
        hi_x = {1'b0, ref_opt} + {1'b0, win};
        lo_x = (ref_opt >= win) ? {1'b0, ref_opt - win} : '0;
    end

    // Window membership test on the first reading.
    always_comb begin
        risky = ({1'b0, v1} >= lo_x) && ({1'b0, v1} <= hi_x);
    end

    // Saturating leakage and fast/slow decision.
    always_comb begin
        drop = (v1 >= v2) ? (v1 - v2) : '0;
        fast = (drop >= fast_thr);
    end

    // Plain threshold decode of the first reading.
    always_comb begin
        if (v1 < ref_lo) begin
            plain_lvl = LVL_ER;
        end else if (v1 < ref_mid) begin
            plain_lvl = LVL_L1;
        end else if (v1 < ref_opt) begin
            plain_lvl = LVL_L2;
        end else begin
            plain_lvl = LVL_L3;
        end
    end

    // Final level: leakage speed overrides the decode for risky cells.
    always_comb begin
        if (risky) begin
            lvl = fast ? LVL_L3 : LVL_L2;
        end else begin
            lvl = plain_lvl;
        end
        changed = risky && (lvl != plain_lvl);
    end

endmodule

// File: rtl/lr_outslot.sv
// Single-entry output register for the corrected-cell stream.
// Loads on an accepted cell and empties on a consumer transfer. A flush
// drops any pending word. Assumes load is only raised when the slot is
// empty or being drained in the same cycle.
module lr_outslot
    import leak_recover_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      load,
    input  out_word_t d,
    input  logic      out_ready,
    output logic      out_valid,
    output out_word_t q
);

    // Hold or replace the pending corrected cell.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            out_valid <= 1'b0;
            q         <= '0;
        end else if (load) begin
            out_valid <= 1'b1;
            q         <= d;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/lr_ctrl.sv
// Page controller: opens a page on start, counts accepted cells against
// the latched page length, keeps the risky/changed statistics and raises
// done after the last output transfer. Assumes start is a one-cycle pulse.
module lr_ctrl
    import leak_recover_pkg::*;
#(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] page_cells,
    input  logic          in_valid,
    input  logic          slot_free,
    input  logic          cell_risky,
    input  logic          cell_changed,
    input  logic          last_fire,
    output logic          in_ready,
    output logic          accept,
    output logic          is_last,
    output logic          done,
    output logic [CW-1:0] risky_cnt,
    output logic [CW-1:0] changed_cnt
);

    phase_t        phase;
    logic [CW-1:0] page_len;
    logic [CW-1:0] taken;

    // Input handshake and last-cell detection.
    always_comb begin
        in_ready = (phase == PH_RUN) && !start && (taken != page_len) && slot_free;
        accept   = in_valid && in_ready;
        is_last  = ((taken + CW'(1)) == page_len);
        done     = (phase == PH_DONE);
    end

    // Phase, cell count and statistics.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            page_len    <= '0;
            taken       <= '0;
            risky_cnt   <= '0;
            changed_cnt <= '0;
        end else if (start) begin
            phase       <= (page_cells == '0) ? PH_DONE : PH_RUN;
            page_len    <= page_cells;
            taken       <= '0;
            risky_cnt   <= '0;
            changed_cnt <= '0;
        end else begin
            if (accept) begin
                taken <= taken + CW'(1);
                if (cell_risky) begin
                    risky_cnt <= risky_cnt + CW'(1);
                end
                if (cell_changed) begin
                    changed_cnt <= changed_cnt + CW'(1);
                end
            end
            if ((phase == PH_RUN) && last_fire) begin
                phase <= PH_DONE;
            end
        end
    end

endmodule

// File: rtl/leak_recover_top.sv
// Leakage-speed cell state recovery engine, top level.
// Streams sample pairs in, classifies one cell per cycle, and streams
// corrected two-bit levels out through a one-entry output slot.
// Assumes references and window stay constant during a page.
module leak_recover_top
    import leak_recover_pkg::*;
#(
    parameter int VW        = 8,
    parameter int MAX_CELLS = 4096,
    localparam int CW       = $clog2(MAX_CELLS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] page_cells,
    input  logic [VW-1:0] ref_lo,
    input  logic [VW-1:0] ref_mid,
    input  logic [VW-1:0] ref_opt,
    input  logic [VW-1:0] win,
    input  logic [VW-1:0] fast_thr,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [VW-1:0] in_v1,
    input  logic [VW-1:0] in_v2,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [1:0]    out_lvl,
    output logic [CW-1:0] risky_cnt,
    output logic [CW-1:0] changed_cnt,
    output logic          done
);

    logic      c_risky;
    logic      c_changed;
    logic [1:0] c_lvl;
    logic      accept;
    logic      is_last;
    logic      slot_free;
    logic      last_fire;
    out_word_t slot_d;
    out_word_t slot_q;

    lr_classify #(.VW(VW)) u_cls (
        .v1       (in_v1),
        .v2       (in_v2),
        .ref_lo   (ref_lo),
        .ref_mid  (ref_mid),
        .ref_opt  (ref_opt),
        .win      (win),
        .fast_thr (fast_thr),
        .lvl      (c_lvl),
        .risky    (c_risky),
        .changed  (c_changed)
    );

    // Output slot status and word to load.
    always_comb begin
        slot_free  = !out_valid || out_ready;
        last_fire  = out_valid && out_ready && slot_q.last;
        slot_d.lvl = c_lvl;
        slot_d.last = is_last;
        out_lvl    = slot_q.lvl;
    end

    lr_ctrl #(.CW(CW)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .page_cells   (page_cells),
        .in_valid     (in_valid),
        .slot_free    (slot_free),
        .cell_risky   (c_risky),
        .cell_changed (c_changed),
        .last_fire    (last_fire),
        .in_ready     (in_ready),
        .accept       (accept),
        .is_last      (is_last),
        .done         (done),
        .risky_cnt    (risky_cnt),
        .changed_cnt  (changed_cnt)
    );

    lr_outslot u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (start),
        .load      (accept),
        .d         (slot_d),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .q         (slot_q)
    );

endmodule

// File: rtl/lr_checker.sv
// Protocol and statistics properties of the recovery engine, bound to
// the top module. Observes ports only.
module lr_checker #(
    parameter int CW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [1:0]    out_lvl,
    input logic          done,
    input logic [CW-1:0] risky_cnt,
    input logic [CW-1:0] changed_cnt
);

    AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !start) |=> (out_valid && $stable(out_lvl))); // R7

    AST_OUT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready)); // R6

    AST_NO_TAKE_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready); // R8

    AST_CHANGED_LE_RISKY: assert property (@(posedge clk) disable iff (!rst_n)
        changed_cnt <= risky_cnt); // R9

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R10

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (risky_cnt == '0 && changed_cnt == '0 && !out_valid)); // R10

endmodule

bind leak_recover_top lr_checker #(.CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_lvl     (out_lvl),
    .done        (done),
    .risky_cnt   (risky_cnt),
    .changed_cnt (changed_cnt)
);

// File: tb/sim_leak_recover_top.sv
`timescale 1ns/1ps
module sim_leak_recover_top;

    localparam int VW = 8;
    localparam int MAX_CELLS = 4096;
    localparam int CW = $clog2(MAX_CELLS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [CW-1:0] page_cells = '0;
    logic [VW-1:0] ref_lo = '0, ref_mid = '0, ref_opt = '0, win = '0, fast_thr = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [VW-1:0] in_v1 = '0, in_v2 = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [1:0]    out_lvl;
    logic [CW-1:0] risky_cnt, changed_cnt;
    logic          done;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    int v1a [64];
    int v2a [64];

    always #2 clk = ~clk;

    leak_recover_top #(.VW(VW), .MAX_CELLS(MAX_CELLS)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .page_cells(page_cells),
        .ref_lo(ref_lo), .ref_mid(ref_mid), .ref_opt(ref_opt), .win(win),
        .fast_thr(fast_thr), .in_valid(in_valid), .in_ready(in_ready),
        .in_v1(in_v1), .in_v2(in_v2), .out_valid(out_valid), .out_ready(out_ready),
        .out_lvl(out_lvl), .risky_cnt(risky_cnt), .changed_cnt(changed_cnt), .done(done)
    );

    // Watchdog: counts as a failed check and still prints the summary.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog act=%0d exp=%0d", cyc, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Expected level from the requirements (R2..R5).
    task automatic model(input int v1, input int v2, output int lvl,
                         output bit risky, output bit chg);
        int plain, lo, hi, drop;
        if (v1 < ref_lo) plain = 3;
        else if (v1 < ref_mid) plain = 2;
        else if (v1 < ref_opt) plain = 0;
        else plain = 1;
        lo = int'(ref_opt) - int'(win);
        hi = int'(ref_opt) + int'(win);
        risky = (v1 >= lo) && (v1 <= hi);
        drop = (v1 > v2) ? v1 - v2 : 0;
        if (risky) lvl = (drop >= fast_thr) ? 1 : 0;
        else lvl = plain;
        chg = risky && (lvl != plain);
    endtask

    // Runs one page of n cells from v1a/v2a; bp enables random stalls.
    task automatic run_page(input int n, input bit bp, input string tag);
        int tx = 0;
        int rx = 0;
        int extra = 0;
        int guard = 0;
        int erisky = 0;
        int echg = 0;
        int el;
        bit er, ec;
        for (int i = 0; i < n; i++) begin
            model(v1a[i], v2a[i], el, er, ec);
            erisky += int'(er);
            echg += int'(ec);
        end
        @(negedge clk);
        start = 1'b1; page_cells = CW'(n); in_valid = 1'b0; out_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        forever begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = bp ? lfsr[0] : 1'b1;
            in_valid = (tx >= n) ? 1'b1 : (bp ? lfsr[3] : 1'b1);
            if (tx < n) begin
                in_v1 = VW'(v1a[tx]); in_v2 = VW'(v2a[tx]);
            end else begin
                in_v1 = ref_opt; in_v2 = '0;
            end
            #1;
            if (done || guard > 3000) break;
            if (out_valid && out_ready) begin
                model(v1a[rx], v2a[rx], el, er, ec);
                chk(int'(out_lvl) == el, tag, int'(out_lvl), el);
                rx++;
            end
            if (in_valid && in_ready) begin
                if (tx >= n) extra++;
                else tx++;
            end
            guard++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(rx == n, "R6 cell count out", rx, n);
        chk(extra == 0, "R8 overrun", extra, 0);
        chk(done == 1'b1, "R10 done", int'(done), 1);
        chk(int'(risky_cnt) == erisky, "R9 risky count", int'(risky_cnt), erisky);
        chk(int'(changed_cnt) == echg, "R9 changed count", int'(changed_cnt), echg);
    endtask

    task automatic set_cfg(input int a, input int b, input int o, input int w, input int t);
        ref_lo = VW'(a); ref_mid = VW'(b); ref_opt = VW'(o); win = VW'(w); fast_thr = VW'(t);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!in_ready && !out_valid && !done, "R1 reset outputs", int'({in_ready, out_valid, done}), 0);
        chk(risky_cnt == 0 && changed_cnt == 0, "R1 reset counters", int'(risky_cnt), 0);
        rst_n = 1'b1;
        in_valid = 1'b1;
        @(negedge clk);
        chk(!in_ready && !done, "R1 idle before start", int'(in_ready), 0);
        in_valid = 1'b0;
    endtask

    task automatic t_levels();
        int pts [8] = '{0, 39, 40, 89, 90, 143, 157, 255};
        set_cfg(40, 90, 150, 6, 10);
        foreach (pts[i]) begin v1a[i] = pts[i]; v2a[i] = pts[i] > 30 ? pts[i] - 30 : 0; end
        run_page(8, 1'b0, "R2 plain decode");
    endtask

    task automatic t_window();
        int p1 [8] = '{144, 144, 156, 156, 150, 150, 143, 157};
        int dr [8] = '{0, 20, 0, 20, 3, 25, 40, 0};
        set_cfg(40, 90, 150, 6, 10);
        foreach (p1[i]) begin v1a[i] = p1[i]; v2a[i] = p1[i] - dr[i]; end
        run_page(8, 1'b0, "R3 R5 window edges");
    endtask

    task automatic t_drop();
        set_cfg(40, 90, 150, 6, 10);
        v1a[0] = 148; v2a[0] = 139;
        v1a[1] = 148; v2a[1] = 138;
        v1a[2] = 148; v2a[2] = 200;
        v1a[3] = 152; v2a[3] = 142;
        v1a[4] = 152; v2a[4] = 143;
        run_page(5, 1'b0, "R4 leakage threshold");
    endtask

    task automatic t_clamp();
        set_cfg(1, 2, 4, 10, 10);
        v1a[0] = 0; v2a[0] = 0;
        v1a[1] = 14; v2a[1] = 0;
        v1a[2] = 15; v2a[2] = 15;
        run_page(3, 1'b0, "R3 low bound clamp");
        set_cfg(40, 90, 250, 10, 30);
        v1a[0] = 255; v2a[0] = 200;
        v1a[1] = 240; v2a[1] = 235;
        v1a[2] = 239; v2a[2] = 239;
        run_page(3, 1'b0, "R3 high bound no wrap");
    endtask

    task automatic t_stream();
        set_cfg(50, 100, 160, 8, 12);
        for (int i = 0; i < 48; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            v1a[i] = (i % 3 == 0) ? 150 + (lfsr[4:0] % 21) : int'(lfsr[7:0]);
            v2a[i] = v1a[i] - int'(lfsr[12:8] % 24);
            if (v2a[i] < 0) v2a[i] = 0;
        end
        run_page(48, 1'b1, "R6 R7 stalled stream");
    endtask

    task automatic t_restart();
        run_page(0, 1'b0, "R10 empty page");
        chk(risky_cnt == 0 && changed_cnt == 0, "R10 start clears", int'(risky_cnt), 0);
    endtask

    initial begin
        t_reset();
        t_levels();
        t_window();
        t_drop();
        t_clamp();
        t_stream();
        t_restart();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule